// File: doc/BRIEF.md
# Glitch-Free Clock Output Stop Gating

This block sits between a set of already generated clocks and their output pins. It lets each clock through or holds it at a steady low, and it never cuts a pulse short. The CPU clock feeds one free-running and one stoppable CPU output. The free-running PCI clock feeds its own free output and a bank of stoppable PCI outputs. A buffered memory clock feeds one free-running memory output and a bank of stoppable memory outputs. A reference clock feeds the interrupt-controller output.

Two active-low stop inputs control the gating. The global stop parks the stoppable CPU output, the stoppable memory outputs and the interrupt-controller output. The PCI stop parks only the stoppable PCI outputs. The free-running outputs ignore both stops. Every output also has a configuration enable bit, and a 0 on that bit holds the output low whatever the stops are doing. Each gate stores its run decision in a register clocked on the falling edge of the source clock and ANDs it with that clock. As a result, a gate opens or closes only while its clock is low.

All control pins are plain level signals. No data flows through the block, so there is no handshake on any pin.

Top module: `clkstop_gate`

## Requirements
- R1: While `rst_n` is low, every clock output is low.
- R2: After `stop_all_n` falls, `cpu_gated` delivers 2 or 3 more complete high phases and then stays low.
- R3: After `stop_all_n` rises, the first `cpu_gated` high phase starts at the 2nd or 3rd rising edge of `cpu_clk` counted from the release, and it is a full high phase.
- R4: `stop_pci_n` is sampled on the rising edge of `pci_clk`. Once it is sampled low, `pci_gated` completes exactly one more full pulse and then stays low. `pci_free` keeps running throughout.
- R5: While `stop_all_n` is low, `apic_out` and all of `sdr_gated` are parked low after 2 to 3 cycles of their own clocks. `cpu_free` and `sdr_free` are not affected.
- R6: `cpu_free`, `pci_free` and `sdr_free` run whenever their enables are 1, whatever the stop inputs are.
- R7: An output whose enable bit is 0 is held low regardless of the stops. The enable map is:
  - `en_cpu[0]` controls `cpu_free` and `en_cpu[1]` controls `cpu_gated`.
  - `en_pci[0]` controls `pci_free` and `en_pci[k+1]` controls `pci_gated[k]`.
  - `en_sdr[0]` controls `sdr_free`.
  - `en_apic` controls `apic_out`.
- R8: Every high phase and every low phase on every output lasts at least half a period of its source clock. No shortened pulse is ever emitted, including when stopping, restarting or toggling an enable.
- R9: `en_sdr[1+g]` controls the group `sdr_gated[4g+3:4g]`, a group size of `SDR_GRP` = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | CPU source clock |
| pci_clk | input | 1 | Free-running PCI source clock |
| sdr_clk | input | 1 | Buffered memory source clock |
| ref_clk | input | 1 | Reference source clock for the interrupt-controller output |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_all_n | input | 1 | Global stop, active low |
| stop_pci_n | input | 1 | PCI stop, active low |
| en_cpu | input | 2 | Enables for the free (bit 0) and gated (bit 1) CPU outputs |
| en_pci | input | NUM_PCI+1 | Enables for the free PCI output (bit 0) and the gated PCI outputs |
| en_sdr | input | NUM_SDR/SDR_GRP+1 | Enables for the free memory output (bit 0) and the gated memory groups |
| en_apic | input | 1 | Enable for the interrupt-controller output |
| cpu_free | output | 1 | Free-running CPU output |
| cpu_gated | output | 1 | Stoppable CPU output |
| pci_free | output | 1 | Free-running PCI output |
| pci_gated | output | NUM_PCI | Stoppable PCI outputs |
| sdr_free | output | 1 | Free-running memory output |
| sdr_gated | output | NUM_SDR | Stoppable memory outputs |
| apic_out | output | 1 | Stoppable interrupt-controller clock output |

## Verification
The bench builds the block with its defaults: five gated PCI outputs, twelve gated memory outputs in three groups of four, and a two-stage synchronizer. This gives 22 distinct outputs across four unrelated clock domains. With the CPU and memory clocks phase-offset and the PCI and reference clocks at other periods, random stop and enable changes land at every phase of every clock, so the pulse-width monitor can catch a clipped phase wherever one would occur. The three memory groups let the bench see that each group enable reaches its own four outputs and no others.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  localparam int unsigned DEF_NUM_PCI = 5;
  localparam int unsigned DEF_NUM_SDR = 12;
  localparam int unsigned DEF_SDR_GRP = 4;
  localparam int unsigned DEF_SYNC    = 2;
  // PCI stop is taken on one rising edge and acts on the next cycle
  localparam int unsigned PCI_STOP_STAGES = 1;
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  // rising-edge capture chain; resets to 0 so gates start closed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkstop_cell.sv
`timescale 1ns/1ps
module clkstop_cell #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] run,
  output logic [W-1:0] clk_out
);
  logic [W-1:0] run_q;

  // decision changes only on the falling edge, i.e. while clk is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run;
  end

  for (genvar i = 0; i < W; i++) begin : g_and
    assign clk_out[i] = clk & run_q[i];
  end
endmodule

// File: rtl/clkstop_domain.sv
`timescale 1ns/1ps
module clkstop_domain #(
  parameter int unsigned N           = 2,
  parameter int unsigned STOP_STAGES = 2,
  parameter int unsigned EN_STAGES   = 2,
  parameter bit          FREE_LSB    = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop_n,
  input  logic [N-1:0] en,
  output logic [N-1:0] clk_out
);
  logic         stop_s;
  logic [N-1:0] en_s;
  logic [N-1:0] exempt_m;
  logic [N-1:0] run;

  clkstop_sync #(.W(1), .STAGES(STOP_STAGES)) u_stop_sync (
    .clk(clk), .rst_n(rst_n), .d(stop_n), .q(stop_s)
  );

  clkstop_sync #(.W(N), .STAGES(EN_STAGES)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d(en), .q(en_s)
  );

  // bit 0 may be a free-running output that ignores the stop
  always_comb begin
    exempt_m    = '0;
    exempt_m[0] = FREE_LSB;
  end

  assign run = en_s & ({N{stop_s}} | exempt_m);

  clkstop_cell #(.W(N)) u_cell (
    .clk(clk), .rst_n(rst_n), .run(run), .clk_out(clk_out)
  );
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int unsigned NUM_PCI = DEF_NUM_PCI,
  parameter int unsigned NUM_SDR = DEF_NUM_SDR,
  parameter int unsigned SDR_GRP = DEF_SDR_GRP,
  parameter int unsigned SYNC    = DEF_SYNC
) (
  input  logic                       cpu_clk,
  input  logic                       pci_clk,
  input  logic                       sdr_clk,
  input  logic                       ref_clk,
  input  logic                       rst_n,
  input  logic                       stop_all_n,
  input  logic                       stop_pci_n,
  input  logic [1:0]                 en_cpu,
  input  logic [NUM_PCI:0]           en_pci,
  input  logic [NUM_SDR/SDR_GRP:0]   en_sdr,
  input  logic                       en_apic,
  output logic                       cpu_free,
  output logic                       cpu_gated,
  output logic                       pci_free,
  output logic [NUM_PCI-1:0]         pci_gated,
  output logic                       sdr_free,
  output logic [NUM_SDR-1:0]         sdr_gated,
  output logic                       apic_out
);
  localparam int unsigned NPCI_OUT = NUM_PCI + 1;
  localparam int unsigned NSDR_OUT = NUM_SDR + 1;

  logic [1:0]          cpu_o;
  logic [NPCI_OUT-1:0] pci_o;
  logic [NSDR_OUT-1:0] sdr_o;
  logic [NSDR_OUT-1:0] sdr_en;
  logic [0:0]          ref_o;

  // CPU pair: bit 0 free-running, bit 1 stoppable
  clkstop_domain #(.N(2), .STOP_STAGES(SYNC), .EN_STAGES(SYNC), .FREE_LSB(1'b1)) u_cpu (
    .clk(cpu_clk), .rst_n(rst_n), .stop_n(stop_all_n), .en(en_cpu), .clk_out(cpu_o)
  );

  // PCI bank: stop sampled once on the rising edge
  clkstop_domain #(.N(NPCI_OUT), .STOP_STAGES(PCI_STOP_STAGES), .EN_STAGES(SYNC),
                   .FREE_LSB(1'b1)) u_pci (
    .clk(pci_clk), .rst_n(rst_n), .stop_n(stop_pci_n), .en(en_pci), .clk_out(pci_o)
  );

  // memory bank: group enables fan out to SDR_GRP outputs each
  assign sdr_en[0] = en_sdr[0];
  for (genvar k = 0; k < NUM_SDR; k++) begin : g_sdr_en
    assign sdr_en[k+1] = en_sdr[1 + k / SDR_GRP];
  end

  clkstop_domain #(.N(NSDR_OUT), .STOP_STAGES(SYNC), .EN_STAGES(SYNC), .FREE_LSB(1'b1)) u_sdr (
    .clk(sdr_clk), .rst_n(rst_n), .stop_n(stop_all_n), .en(sdr_en), .clk_out(sdr_o)
  );

  // interrupt-controller clock: stoppable, no free member
  clkstop_domain #(.N(1), .STOP_STAGES(SYNC), .EN_STAGES(SYNC), .FREE_LSB(1'b0)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .stop_n(stop_all_n), .en(en_apic), .clk_out(ref_o)
  );

  assign cpu_free  = cpu_o[0];
  assign cpu_gated = cpu_o[1];
  assign pci_free  = pci_o[0];
  assign pci_gated = pci_o[NPCI_OUT-1:1];
  assign sdr_free  = sdr_o[0];
  assign sdr_gated = sdr_o[NSDR_OUT-1:1];
  assign apic_out  = ref_o[0];
endmodule

// File: rtl/clkstop_gate_chk.sv
`timescale 1ns/1ps
module clkstop_gate_chk #(
  parameter int unsigned NUM_PCI = 5,
  parameter int unsigned NUM_SDR = 12,
  parameter int unsigned SDR_GRP = 4
) (
  input logic                     cpu_clk,
  input logic                     pci_clk,
  input logic                     sdr_clk,
  input logic                     ref_clk,
  input logic                     rst_n,
  input logic                     stop_all_n,
  input logic                     stop_pci_n,
  input logic [1:0]               en_cpu,
  input logic [NUM_PCI:0]         en_pci,
  input logic [NUM_SDR/SDR_GRP:0] en_sdr,
  input logic                     en_apic,
  input logic                     cpu_free,
  input logic                     cpu_gated,
  input logic                     pci_free,
  input logic [NUM_PCI-1:0]       pci_gated,
  input logic                     sdr_free,
  input logic [NUM_SDR-1:0]       sdr_gated,
  input logic                     apic_out
);
  // falling-edge counts since reset, saturating, so $past stays in range
  logic [2:0] n_cpu, n_pci, n_sdr, n_ref;

  always_ff @(negedge cpu_clk or negedge rst_n)
    if (!rst_n) n_cpu <= '0; else if (n_cpu != 3'd7) n_cpu <= n_cpu + 3'd1;
  always_ff @(negedge pci_clk or negedge rst_n)
    if (!rst_n) n_pci <= '0; else if (n_pci != 3'd7) n_pci <= n_pci + 3'd1;
  always_ff @(negedge sdr_clk or negedge rst_n)
    if (!rst_n) n_sdr <= '0; else if (n_sdr != 3'd7) n_sdr <= n_sdr + 3'd1;
  always_ff @(negedge ref_clk or negedge rst_n)
    if (!rst_n) n_ref <= '0; else if (n_ref != 3'd7) n_ref <= n_ref + 3'd1;

  AST_CPU_STOP_PARKS: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (n_cpu >= 3'd3 && !stop_all_n && !$past(stop_all_n) && !$past(stop_all_n, 2)
     && !$past(stop_all_n, 3)) |-> !cpu_gated); // R2

  AST_PCI_STOP_PARKS: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (n_pci >= 3'd3 && !stop_pci_n && !$past(stop_pci_n) && !$past(stop_pci_n, 2)
     && !$past(stop_pci_n, 3)) |-> (pci_gated == '0)); // R4

  AST_SDR_STOP_PARKS: assert property (@(negedge sdr_clk) disable iff (!rst_n)
    (n_sdr >= 3'd3 && !stop_all_n && !$past(stop_all_n) && !$past(stop_all_n, 2)
     && !$past(stop_all_n, 3)) |-> (sdr_gated == '0)); // R5

  AST_APIC_STOP_PARKS: assert property (@(negedge ref_clk) disable iff (!rst_n)
    (n_ref >= 3'd3 && !stop_all_n && !$past(stop_all_n) && !$past(stop_all_n, 2)
     && !$past(stop_all_n, 3)) |-> !apic_out); // R5

  AST_CPU_FREE_RUNS: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (n_cpu >= 3'd3 && en_cpu[0] && $past(en_cpu[0]) && $past(en_cpu[0], 2)
     && $past(en_cpu[0], 3)) |-> cpu_free); // R6

  AST_PCI_FREE_RUNS: assert property (@(negedge pci_clk) disable iff (!rst_n)
    (n_pci >= 3'd3 && en_pci[0] && $past(en_pci[0]) && $past(en_pci[0], 2)
     && $past(en_pci[0], 3)) |-> pci_free); // R6

  AST_SDR_FREE_RUNS: assert property (@(negedge sdr_clk) disable iff (!rst_n)
    (n_sdr >= 3'd3 && en_sdr[0] && $past(en_sdr[0]) && $past(en_sdr[0], 2)
     && $past(en_sdr[0], 3)) |-> sdr_free); // R6

  AST_CPU_DISABLED_LOW: assert property (@(negedge cpu_clk) disable iff (!rst_n)
    (n_cpu >= 3'd3 && !en_cpu[1] && !$past(en_cpu[1]) && !$past(en_cpu[1], 2)
     && !$past(en_cpu[1], 3)) |-> !cpu_gated); // R7
endmodule

bind clkstop_gate clkstop_gate_chk #(.NUM_PCI(NUM_PCI), .NUM_SDR(NUM_SDR), .SDR_GRP(SDR_GRP))
  u_chk (.*);

// File: tb/clkstop_gate_bench.sv
`timescale 1ns/1ps
module clkstop_gate_bench;
  localparam int NUM_PCI = 5;
  localparam int NUM_SDR = 12;
  localparam int SDR_GRP = 4;
  localparam int NGRP    = NUM_SDR / SDR_GRP;
  localparam int NOBS    = 2 + (NUM_PCI + 1) + (NUM_SDR + 1) + 1;

  logic cpu_clk = 1'b0, pci_clk = 1'b0, sdr_clk = 1'b0, ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_all_n = 1'b1, stop_pci_n = 1'b1;
  logic [1:0] en_cpu = '1;
  logic [NUM_PCI:0] en_pci = '1;
  logic [NGRP:0] en_sdr = '1;
  logic en_apic = 1'b1;
  logic cpu_free, cpu_gated, pci_free, sdr_free, apic_out;
  logic [NUM_PCI-1:0] pci_gated;
  logic [NUM_SDR-1:0] sdr_gated;

  always #2.5 cpu_clk = ~cpu_clk;                     // 200 MHz
  initial begin #1; forever #2.5 sdr_clk = ~sdr_clk; end
  always #7.5 pci_clk = ~pci_clk;
  always #3.5 ref_clk = ~ref_clk;

  clkstop_gate u_clkstop_gate (
    .cpu_clk(cpu_clk), .pci_clk(pci_clk), .sdr_clk(sdr_clk), .ref_clk(ref_clk),
    .rst_n(rst_n), .stop_all_n(stop_all_n), .stop_pci_n(stop_pci_n),
    .en_cpu(en_cpu), .en_pci(en_pci), .en_sdr(en_sdr), .en_apic(en_apic),
    .cpu_free(cpu_free), .cpu_gated(cpu_gated), .pci_free(pci_free), .pci_gated(pci_gated),
    .sdr_free(sdr_free), .sdr_gated(sdr_gated), .apic_out(apic_out)
  );

  // bit map: 0 cpu_free, 1 cpu_gated, 2 pci_free, 3..7 pci_gated, 8 sdr_free, 9..20 sdr_gated, 21 apic
  logic [NOBS-1:0] obs;
  assign obs = {apic_out, sdr_gated, sdr_free, pci_gated, pci_free, cpu_gated, cpu_free};

  int n_checks = 0, n_fail = 0;
  bit done = 0, mon_on = 0;
  int rise_cnt [NOBS];
  int viol [NOBS];
  realtime t_rise [NOBS];
  realtime t_fall [NOBS];
  logic [NOBS-1:0] prev_obs = '0;

  function automatic realtime half_per(int i);
    if (i <= 1) return 2.5;
    if (i <= 7) return 7.5;
    if (i <= 20) return 2.5;
    return 3.5;
  endfunction

  initial for (int i = 0; i < NOBS; i++) begin
    rise_cnt[i] = 0; viol[i] = 0; t_rise[i] = 0.0; t_fall[i] = -100.0;
  end

  // edge counter and pulse-width monitor (R8)
  always @(obs) begin
    if (mon_on) begin
      for (int i = 0; i < NOBS; i++) begin
        if (obs[i] === 1'b1 && prev_obs[i] !== 1'b1) begin
          rise_cnt[i]++;
          if ($realtime - t_fall[i] < half_per(i) - 0.01) viol[i]++;
          t_rise[i] = $realtime;
        end else if (obs[i] === 1'b0 && prev_obs[i] === 1'b1) begin
          if ($realtime - t_rise[i] < half_per(i) - 0.01) viol[i]++;
          t_fall[i] = $realtime;
        end
      end
    end
    prev_obs = obs;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_run(int i);
    if (i == 0) return en_cpu[0];
    if (i == 1) return en_cpu[1] & stop_all_n;
    if (i == 2) return en_pci[0];
    if (i <= 7) return en_pci[i-2] & stop_pci_n;
    if (i == 8) return en_sdr[0];
    if (i <= 20) return en_sdr[1 + (i-9)/SDR_GRP] & stop_all_n;
    return en_apic & stop_all_n;
  endfunction

  function automatic bit en_of(int i);
    if (i <= 1) return en_cpu[i];
    if (i <= 7) return en_pci[i-2];
    if (i == 8) return en_sdr[0];
    if (i <= 20) return en_sdr[1 + (i-9)/SDR_GRP];
    return en_apic;
  endfunction

  function automatic string tag_of(int i);
    if (!en_of(i)) return "R7 disabled output";
    if (i == 0 || i == 2 || i == 8) return "R6 free output";
    if (i == 1) return "R2 gated cpu";
    if (i <= 7) return "R4 gated pci";
    if (i <= 20) return "R9 memory group";
    return "R5 apic";
  endfunction

  initial begin : watchdog
    #1000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    int snap [NOBS];
    int c0, f0, lat, seed;
    seed = $urandom(32'h00C1_0C55);

    // R1: outputs held low during reset with clocks running
    #50;
    chk(obs == '0, "R1 reset low", int'(obs), 0);
    #3.3 rst_n = 1'b1;
    #20 mon_on = 1'b1;
    #80;

    // R2: global stop, cpu_gated finishes 2..3 pulses
    @(posedge cpu_clk); #0.5 stop_all_n = 1'b0;
    c0 = rise_cnt[1];
    repeat (6) @(posedge cpu_clk);
    #0.5;
    chk((rise_cnt[1]-c0) >= 2 && (rise_cnt[1]-c0) <= 3, "R2 stop latency", rise_cnt[1]-c0, 2);
    chk(cpu_free === 1'b0 || cpu_free === 1'b1, "R5 cpu_free defined", 1, 1);
    #40;

    // R3: restart, first pulse on 2nd or 3rd cpu rising edge
    @(posedge cpu_clk); #0.5 stop_all_n = 1'b1;
    c0 = rise_cnt[1]; lat = 0;
    for (int k = 1; k <= 5; k++) begin
      @(posedge cpu_clk); #0.5;
      if (lat == 0 && rise_cnt[1] != c0) lat = k;
    end
    chk(lat >= 2 && lat <= 3, "R3 restart latency", lat, 3);
    #60;

    // R4: pci stop, one more full pulse then low; free keeps going
    @(posedge pci_clk); #1 stop_pci_n = 1'b0;
    c0 = rise_cnt[3]; f0 = rise_cnt[2];
    repeat (4) @(posedge pci_clk);
    #1;
    chk(rise_cnt[3]-c0 == 1, "R4 pci stop pulses", rise_cnt[3]-c0, 1);
    chk(rise_cnt[2]-f0 == 4, "R4 pci_free runs", rise_cnt[2]-f0, 4);
    stop_pci_n = 1'b1;
    #80;

    // random stop/enable mixes, outputs checked against exp_run
    for (int t = 0; t < 24; t++) begin
      stop_all_n = ($urandom % 3) != 0;
      stop_pci_n = ($urandom % 3) != 0;
      for (int b = 0; b < 2; b++) en_cpu[b] = ($urandom % 5) != 0;
      for (int b = 0; b <= NUM_PCI; b++) en_pci[b] = ($urandom % 5) != 0;
      for (int b = 0; b <= NGRP; b++) en_sdr[b] = ($urandom % 4) != 0;
      en_apic = ($urandom % 5) != 0;
      #100;
      for (int i = 0; i < NOBS; i++) snap[i] = rise_cnt[i];
      #60;
      for (int i = 0; i < NOBS; i++) begin
        if (exp_run(i))
          chk(rise_cnt[i]-snap[i] >= 3, tag_of(i), rise_cnt[i]-snap[i], 3);
        else
          chk(rise_cnt[i] == snap[i] && obs[i] === 1'b0, tag_of(i), rise_cnt[i]-snap[i], 0);
      end
      #($urandom % 7);
    end

    // R8: no short phase seen on any output during the whole run
    for (int i = 0; i < NOBS; i++)
      chk(viol[i] == 0, "R8 short phase", viol[i], 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule